// File: doc/BRIEF.md
# Oscillator Pair Race Response Unit

This unit turns a challenge into a single response bit by racing two free-running oscillator inputs against each other. A bank of nominally identical oscillators feeds the block; each one toggles at its own slightly different frequency. The challenge word names two members of the bank. On a start strobe the block latches that pair, resynchronises both inputs into the system clock domain, and counts their rising edges for a configured number of system clock cycles. When the window closes it reports which of the two counted more edges.

The challenge path is what makes the construction challengeable: without it only fixed pairs could ever be compared. The window length is a configuration input that is held steady while the block is in use. A challenge that names the same oscillator twice is refused, because a unit compared with itself carries no information. Noise handling, key derivation and the oscillators themselves live outside the block.

Top module: `ro_race_top`

## Requirements
- R1: While reset is held and on the first cycle after it, response, tie, done and chalErr are all 0.
- R2: The first index of the challenge is challenge[IDX_W-1:0] and the second index is challenge[2*IDX_W-1:IDX_W]; both are latched when an evaluation is accepted.
- R3: A start seen while idle with two different indices starts an evaluation whose window lasts W = max(windowLen, 1) clock cycles. An oscillator rising edge counts when its input is sampled 0 then 1 on two consecutive clock edges; that edge enters the count two clock edges after the 1 was sampled, and only counts landing on the W edges following the start edge are kept.
- R4: done is high for exactly one cycle, appearing right after the W-th clock edge following the accepted start edge.
- R5: The response bit is 1 when the first selected oscillator counted strictly more edges than the second, otherwise 0.
- R6: When the two counts are equal the response is 0 and tie is 1; otherwise tie is 0.
- R7: Each edge count stops at 2^CNT_W-1 instead of wrapping, so two oscillators that both exceed it give a tie.
- R8: A start with two equal indices is refused: chalErr goes to 1 on the next cycle and stays there until the next start seen while idle, no done pulse follows, and response and tie keep their values.
- R9: A start that arrives while an evaluation is running has no effect: the window is not restarted and the latched pair is not replaced.
- R10: response and tie change only together with a done pulse and stay stable until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oscIn | input | NUM_OSC | Free-running oscillator bank inputs |
| start | input | 1 | Evaluation request strobe |
| challenge | input | 2*IDX_W | Two oscillator indices, first in the low field |
| windowLen | input | WIN_W | Measurement window in clock cycles (0 behaves as 1) |
| response | output | 1 | 1 when the first oscillator counted more edges |
| tie | output | 1 | Counts were equal in the last evaluation |
| done | output | 1 | One-cycle pulse when a result is written |
| chalErr | output | 1 | Last idle start named the same oscillator twice |

## Verification
The bench drives the bank with clocks of several divider ratios, including one pair with identical period and phase, and runs a behavioural model beside the design on every clock. Pairs ordered fast-then-slow and slow-then-fast tell apart the sense of the comparison and the field order of the challenge; the matched pair and a long window over two fast inputs separate a true tie from a saturated one. A repeated index, a start issued mid-window with a different pair, and a zero window length probe the refusal path, the ignoring of busy starts and the minimum window.

// File: rtl/ro_race_pkg.sv
package ro_race_pkg;
  // strobes issued by the control to the counting datapath
  typedef struct packed {
    logic clearCnt;  // load the pair and zero both counters
    logic countEn;   // window open
    logic capture;   // last window cycle: write the result
  } raceStrobe_t;
endpackage

// File: rtl/ro_race_ctrl.sv
module ro_race_ctrl
  import ro_race_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int WIN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2*IDX_W-1:0]   challenge,
  input  logic [WIN_W-1:0]     windowLen,
  output raceStrobe_t          strb,
  output logic                 done,
  output logic                 chalErr
);
  typedef enum logic {ST_IDLE, ST_MEASURE} ctrlState_t;

  ctrlState_t        state;
  logic [WIN_W-1:0]  winCnt;
  logic [WIN_W:0]    winNext;
  logic              winLast;
  logic              sameIdx;
  logic              accept;
  logic              reject;

  assign sameIdx = (challenge[IDX_W-1:0] == challenge[2*IDX_W-1:IDX_W]);
  assign accept  = (state == ST_IDLE) && start && !sameIdx;
  assign reject  = (state == ST_IDLE) && start && sameIdx;
  assign winNext = {1'b0, winCnt} + (WIN_W+1)'(1);
  assign winLast = (winNext >= {1'b0, windowLen});

  always_comb begin
    strb.clearCnt = accept;
    strb.countEn  = (state == ST_MEASURE);
    strb.capture  = (state == ST_MEASURE) && winLast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      done    <= 1'b0;
      chalErr <= 1'b0;
    end else begin
      done <= strb.capture;
      if (state == ST_IDLE && start) chalErr <= reject;
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_MEASURE;
          winCnt <= '0;
        end
        ST_MEASURE: begin
          winCnt <= winNext[WIN_W-1:0];
          if (winLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_no_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chalErr |-> (state == ST_IDLE));
endmodule

// File: rtl/ro_race_datapath.sv
module ro_race_datapath
  import ro_race_pkg::*;
#(
  parameter int NUM_OSC = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_OSC-1:0]   oscIn,
  input  logic [2*IDX_W-1:0]   challenge,
  input  raceStrobe_t          strb,
  output logic                 response,
  output logic                 tie
);
  localparam int PAD_W = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_OSC-1:0] syncA, syncB, syncPrev;
  logic [PAD_W-1:0]   risePad;
  logic [IDX_W-1:0]   sel     [2];
  logic [CNT_W-1:0]   cnt     [2];
  logic [CNT_W-1:0]   cntNext [2];

  // two-flop resynchroniser plus a history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= oscIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign risePad = PAD_W'(syncB & ~syncPrev);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      if (strb.clearCnt)
        cntNext[g] = '0;
      else if (strb.countEn && risePad[sel[g]] && cnt[g] != CNT_MAX)
        cntNext[g] = cnt[g] + CNT_W'(1);
      else
        cntNext[g] = cnt[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[g] <= '0;
        cnt[g] <= '0;
      end else begin
        cnt[g] <= cntNext[g];
        if (strb.clearCnt) sel[g] <= challenge[g*IDX_W +: IDX_W];
      end
    end

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CNT_MAX && !strb.clearCnt) |=> (cnt[g] == CNT_MAX));
    assert_sel_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.countEn && !strb.capture) |=> $stable(sel[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      response <= 1'b0;
      tie      <= 1'b0;
    end else if (strb.capture) begin
      response <= (cntNext[0] > cntNext[1]);
      tie      <= (cntNext[0] == cntNext[1]);
    end
  end

  assert_tie_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tie |-> !response);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> ($stable(response) && $stable(tie)));
endmodule

// File: rtl/ro_race_top.sv
module ro_race_top
  import ro_race_pkg::*;
#(
  parameter int NUM_OSC = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 16,
  localparam int IDX_W  = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_OSC-1:0]   oscIn,
  input  logic                 start,
  input  logic [2*IDX_W-1:0]   challenge,
  input  logic [WIN_W-1:0]     windowLen,
  output logic                 response,
  output logic                 tie,
  output logic                 done,
  output logic                 chalErr
);
  raceStrobe_t strb;

  ro_race_ctrl #(.IDX_W(IDX_W), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .windowLen(windowLen), .strb(strb), .done(done), .chalErr(chalErr)
  );

  ro_race_datapath #(.NUM_OSC(NUM_OSC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .oscIn(oscIn), .challenge(challenge),
    .strb(strb), .response(response), .tie(tie)
  );

  assert_err_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chalErr && $past(chalErr)) |-> !done);
endmodule

// File: tb/ro_race_top_bench.sv
`timescale 1ns/1ps
module ro_race_top_bench;
  localparam int NOSC  = 8;
  localparam int IDXW  = 3;
  localparam int CNTW  = 5;
  localparam int WINW  = 10;
  localparam int CMAX  = (1 << CNTW) - 1;
  localparam int HALF [NOSC] = '{1, 2, 3, 5, 4, 4, 7, 9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NOSC-1:0] oscIn = '0;
  logic start = 1'b0;
  logic [2*IDXW-1:0] challenge = '0;
  logic [WINW-1:0] windowLen = '0;
  logic response, tie, done, chalErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ro_race_top #(.NUM_OSC(NOSC), .CNT_W(CNTW), .WIN_W(WINW)) u_ro_race_top (
    .clk(clk), .rst_n(rst_n), .oscIn(oscIn), .start(start),
    .challenge(challenge), .windowLen(windowLen), .response(response),
    .tie(tie), .done(done), .chalErr(chalErr)
  );

  // free-running oscillator bank, each a divided clock changing at negedge
  int divCnt [NOSC];
  initial for (int i = 0; i < NOSC; i++) divCnt[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < NOSC; i++) begin
      if (divCnt[i] == HALF[i] - 1) begin
        divCnt[i] = 0;
        oscIn[i] <= ~oscIn[i];
      end else divCnt[i] = divCnt[i] + 1;
    end
  end

  // behavioural reference model
  logic [NOSC-1:0] h1, h2, h3;
  bit mBusy, mDone, mResp, mTie, mErr;
  int mWcnt, mWin, mA, mB, mCa, mCb;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      mBusy = 0; mDone = 0; mResp = 0; mTie = 0; mErr = 0;
      mWcnt = 0; mWin = 1; mA = 0; mB = 0; mCa = 0; mCb = 0;
    end else begin
      logic [NOSC-1:0] rise;
      bit nextDone;
      rise = h2 & ~h3;
      nextDone = 0;
      if (mBusy) begin
        mWcnt++;
        if (rise[mA] && mCa < CMAX) mCa++;
        if (rise[mB] && mCb < CMAX) mCb++;
        if (mWcnt == mWin) begin
          mBusy = 0;
          nextDone = 1;
          mResp = (mCa > mCb);
          mTie = (mCa == mCb);
        end
      end else if (start) begin
        int a, b;
        a = int'(challenge[IDXW-1:0]);
        b = int'(challenge[2*IDXW-1:IDXW]);
        if (a == b) mErr = 1;
        else begin
          mErr = 0; mBusy = 1; mWcnt = 0;
          mWin = (windowLen == 0) ? 1 : int'(windowLen);
          mA = a; mB = b; mCa = 0; mCb = 0;
        end
      end
      mDone = nextDone;
      h3 = h2; h2 = h1; h1 = oscIn;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done !== mDone) begin
        errors++;
        $display("FAIL R3 R4 R9 done actual=%0b expected=%0b t=%0t", done, mDone, $time);
      end
      checks++;
      if (response !== mResp) begin
        errors++;
        $display("FAIL R2 R5 R10 response actual=%0b expected=%0b t=%0t", response, mResp, $time);
      end
      checks++;
      if (tie !== mTie) begin
        errors++;
        $display("FAIL R6 R7 tie actual=%0b expected=%0b t=%0t", tie, mTie, $time);
      end
      checks++;
      if (chalErr !== mErr) begin
        errors++;
        $display("FAIL R8 chalErr actual=%0b expected=%0b t=%0t", chalErr, mErr, $time);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pulseStart(input int a, input int b);
    @(negedge clk);
    challenge = {IDXW'(b), IDXW'(a)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runEval(input int a, input int b, input int win);
    windowLen = WINW'(win);
    pulseStart(a, b);
    repeat (win + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 response in reset", response, 1'b0);
    check("R1 done in reset", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tie after reset", tie, 1'b0);
    check("R1 chalErr after reset", chalErr, 1'b0);

    runEval(0, 2, 60);   // R5 fast first -> 1
    check("R5 fast first", response, 1'b1);
    runEval(2, 0, 60);   // R2 field order reversed -> 0
    check("R2 slow first", response, 1'b0);
    runEval(6, 7, 120);  // R5 close frequencies
    runEval(4, 5, 80);   // R6 matched pair
    check("R6 matched pair tie", tie, 1'b1);
    runEval(3, 3, 4);    // R8 refused
    check("R8 refused flag", chalErr, 1'b1);
    check("R8 tie kept", tie, 1'b1);
    runEval(0, 1, 200);  // R7 both saturate
    check("R7 saturated tie", tie, 1'b1);
    check("R7 saturated response", response, 1'b0);

    // R9 busy start with a different pair is ignored
    windowLen = WINW'(90);
    pulseStart(7, 3);
    repeat (10) @(negedge clk);
    pulseStart(1, 2);
    repeat (90) @(negedge clk);
    check("R9 original pair result", response, 1'b0);

    runEval(1, 2, 0);    // R3 zero window acts as one cycle
    runEval(3, 1, 40);
    runEval(5, 6, 150);
    check("R10 final stable", response, mResp);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule